// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Timing Model

This block is a cycle-accurate occupancy model of an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. It carries no datapath. A driver feeds it a trace of instruction descriptors through a valid/ready handshake. Each descriptor names a destination register, two source registers, a used flag for each source, a register-write enable, a load marker, a branch marker and the branch outcome. On every cycle the block shows which stages hold an instruction and which hold a bubble. Each accepted instruction carries a sequence tag, so the driver can follow it through the stages.

The block decides stalls and flushes from two run-time settings. One setting turns operand forwarding on or off. The other selects the branch policy: flush on every branch, or predict not-taken. The trace given to the block is the fetched stream, so it includes any wrong-path instructions. A flush squashes those instructions and they never retire. Four saturating counters record elapsed cycles, retired instructions, stall cycles and flush penalty cycles. From these the driver can work out cycles per instruction.

Top module: `hzpipe_model`

## Requirements
- R1: While `rst` is high at a clock edge, every stage becomes a bubble, all four counters become zero and the next tag becomes 0. After reset, `in_ready` is high as long as `drain` is low.
- R2: With no hazards, every instruction moves one stage per cycle. Occupancy bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory and bit 4 writeback. Ten independent instructions accepted on consecutive edges after reset give 10 retired and 15 cycles after 15 edges.
- R3: A decode-stage source depends on an older instruction only when all three of these hold: its used flag is set, the producer has its write enable set, and the producer's destination matches the source and is not register 0.
- R4: With forwarding off, a decode instruction that depends on the execute-stage or memory-stage instruction stalls. A back-to-back dependency therefore costs exactly 2 stall cycles.
- R5: With forwarding on, only a dependency on a load that sits in execute stalls, and it stalls for exactly 1 cycle. A dependency on a non-load instruction costs nothing.
- R6: In a stall cycle, `in_ready` is low, the fetch and decode contents hold, and a bubble enters execute. The stall counter adds 1.
- R7: A flushing branch in execute turns the decode and execute stages into bubbles at the next edge. The branch itself moves on to memory. In that cycle fetch takes the newly accepted descriptor. The flush counter adds 2, and a flush overrides any stall in the same cycle.
- R8: With `cfg_predict_nt` low, every branch flushes. With it high, only a branch whose taken flag is set flushes.
- R9: The cycle counter adds 1 at every edge out of reset. The retired counter adds 1 for each edge at which writeback holds an instruction, and never for a bubble.
- R10: Each counter saturates at its all-ones value and does not wrap.
- R11: While `drain` is high, `in_ready` is low, so the pipeline empties.
- R12: Accepted descriptors get consecutive tags, starting at 0 after reset and wrapping modulo 2^8. An accepted descriptor sits in fetch at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor taken at this edge if valid |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_rs1_used | input | 1 | First source is read |
| in_rs2_used | input | 1 | Second source is read |
| in_wr_en | input | 1 | Instruction writes a register |
| in_is_load | input | 1 | Instruction is a load |
| in_is_branch | input | 1 | Instruction is a branch |
| in_br_taken | input | 1 | Branch outcome |
| cfg_forward | input | 1 | Forwarding enabled |
| cfg_predict_nt | input | 1 | 1 = predict not-taken, 0 = flush every branch |
| drain | input | 1 | Stop accepting descriptors |
| occ_valid | output | 5 | Stage holds an instruction (bit 0 fetch .. bit 4 writeback) |
| occ_tags | output | 40 | Tag per stage, 8 bits each, fetch in the low byte |
| cnt_cycles | output | 32 | Elapsed cycles |
| cnt_retired | output | 32 | Retired instructions |
| cnt_stalls | output | 32 | Stall cycles |
| cnt_flush_bubbles | output | 32 | Flush penalty cycles |

## Verification
The assertions check on every cycle how a stall or flush acts on the stages and the handshake. A stall must hold fetch and decode, put a bubble into execute and drop `in_ready`. A flush must empty decode and execute, and it must come from a branch in execute. With forwarding on, a stall is only allowed behind a load. The assertions also check that the counters step and saturate correctly. The bench scenarios are needed to show the penalty totals: two cycles for a back-to-back dependency without forwarding, one for load-use, none for a not-taken branch under prediction. They also show that a zero destination, an unused source or a non-writing producer creates no dependency. The bench compares tag movement and counter totals against its own model over random mixed traces in all four setting combinations.

// File: rtl/hzp_pkg.sv
package hzp_pkg;

    localparam int REG_AW = 5;
    localparam int TAG_W  = 8;
    localparam int NSTG   = 5;

    localparam int IF_S  = 0;
    localparam int ID_S  = 1;
    localparam int EX_S  = 2;
    localparam int MEM_S = 3;
    localparam int WB_S  = 4;

    localparam int FLUSH_COST = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic     valid;
        tag_t     tag;
        reg_idx_t rd;
        reg_idx_t rs1;
        reg_idx_t rs2;
        logic     rs1_use;
        logic     rs2_use;
        logic     wen;
        logic     load;
        logic     branch;
        logic     taken;
    } instr_t;

    localparam instr_t BUBBLE = '0;

    // True when consumer c needs the result that producer p will write.
    function automatic logic reads_from(instr_t c, instr_t p);
        logic prod_ok;
        logic hit1;
        logic hit2;
        prod_ok = p.valid && p.wen && (p.rd != '0);
        hit1    = c.rs1_use && (c.rs1 == p.rd);
        hit2    = c.rs2_use && (c.rs2 == p.rd);
        return c.valid && prod_ok && (hit1 || hit2);
    endfunction

    // True when a branch sitting in execute must squash the younger work.
    function automatic logic branch_flushes(instr_t b, logic predict_nt);
        return b.valid && b.branch && (!predict_nt || b.taken);
    endfunction

endpackage

// File: rtl/hzp_hazard.sv
module hzp_hazard
    import hzp_pkg::*;
(
    input  instr_t id_i,
    input  instr_t ex_i,
    input  instr_t mem_i,
    input  logic   fwd_en_i,
    input  logic   predict_nt_i,
    output logic   stall_o,
    output logic   flush_o
);

    logic dep_ex;
    logic dep_mem;
    logic hazard;

    always_comb begin
        dep_ex  = reads_from(id_i, ex_i);
        dep_mem = reads_from(id_i, mem_i);
        if (fwd_en_i) begin
            hazard = dep_ex && ex_i.load;
        end else begin
            hazard = dep_ex || dep_mem;
        end
        flush_o = branch_flushes(ex_i, predict_nt_i);
        stall_o = hazard && !flush_o;
    end

endmodule

// File: rtl/hzp_stages.sv
module hzp_stages
    import hzp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  instr_t fetch_i,
    input  logic   stall_i,
    input  logic   flush_i,
    output instr_t stage_o [NSTG]
);

    instr_t stage_q [NSTG];

    // Front of the pipe: fetch, decode and execute react to stall and flush.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q[IF_S] <= BUBBLE;
            stage_q[ID_S] <= BUBBLE;
            stage_q[EX_S] <= BUBBLE;
        end else if (flush_i) begin
            stage_q[IF_S] <= fetch_i;
            stage_q[ID_S] <= BUBBLE;
            stage_q[EX_S] <= BUBBLE;
        end else if (stall_i) begin
            stage_q[EX_S] <= BUBBLE;
        end else begin
            stage_q[IF_S] <= fetch_i;
            stage_q[ID_S] <= stage_q[IF_S];
            stage_q[EX_S] <= stage_q[ID_S];
        end
    end

    // Back of the pipe always advances.
    for (genvar g = MEM_S; g < NSTG; g++) begin : g_tail
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= BUBBLE;
            end else begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_out
        assign stage_o[g] = stage_q[g];
    end

endmodule

// File: rtl/hzp_satcnt.sv
module hzp_satcnt #(
    parameter int W     = 32,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc_i,
    output logic [W-1:0]     count_o
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] sum;
    logic [W-1:0]     count_q;

    always_comb begin
        sum = {1'b0, count_q} + SUM_W'(inc_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (sum[W]) begin
            count_q <= '1;
        end else begin
            count_q <= sum[W-1:0];
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/hzpipe_model.sv
module hzpipe_model
    import hzp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [REG_AW-1:0]       in_rd,
    input  logic [REG_AW-1:0]       in_rs1,
    input  logic [REG_AW-1:0]       in_rs2,
    input  logic                    in_rs1_used,
    input  logic                    in_rs2_used,
    input  logic                    in_wr_en,
    input  logic                    in_is_load,
    input  logic                    in_is_branch,
    input  logic                    in_br_taken,
    input  logic                    cfg_forward,
    input  logic                    cfg_predict_nt,
    input  logic                    drain,
    output logic [NSTG-1:0]         occ_valid,
    output logic [NSTG*TAG_W-1:0]   occ_tags,
    output logic [CNT_W-1:0]        cnt_cycles,
    output logic [CNT_W-1:0]        cnt_retired,
    output logic [CNT_W-1:0]        cnt_stalls,
    output logic [CNT_W-1:0]        cnt_flush_bubbles
);

    localparam int NCNT  = 4;
    localparam int INC_W = $clog2(FLUSH_COST + 1);

    instr_t stage [NSTG];
    instr_t fetch;
    tag_t   next_tag;
    logic   stall;
    logic   flush;
    logic   accept;

    logic [INC_W-1:0] cnt_inc [NCNT];
    logic [CNT_W-1:0] cnt_val [NCNT];

    hzp_hazard u_hazard (
        .id_i         (stage[ID_S]),
        .ex_i         (stage[EX_S]),
        .mem_i        (stage[MEM_S]),
        .fwd_en_i     (cfg_forward),
        .predict_nt_i (cfg_predict_nt),
        .stall_o      (stall),
        .flush_o      (flush)
    );

    assign in_ready = !stall && !drain;
    assign accept   = in_valid && in_ready;

    always_comb begin
        fetch         = BUBBLE;
        fetch.valid   = accept;
        fetch.tag     = next_tag;
        fetch.rd      = in_rd;
        fetch.rs1     = in_rs1;
        fetch.rs2     = in_rs2;
        fetch.rs1_use = in_rs1_used;
        fetch.rs2_use = in_rs2_used;
        fetch.wen     = in_wr_en;
        fetch.load    = in_is_load;
        fetch.branch  = in_is_branch;
        fetch.taken   = in_br_taken;
        if (!accept) begin
            fetch = BUBBLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_tag <= '0;
        end else if (accept) begin
            next_tag <= next_tag + 1'b1;
        end
    end

    hzp_stages u_stages (
        .clk     (clk),
        .rst     (rst),
        .fetch_i (fetch),
        .stall_i (stall),
        .flush_i (flush),
        .stage_o (stage)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_occ
        assign occ_valid[g]                = stage[g].valid;
        assign occ_tags[g*TAG_W +: TAG_W]  = stage[g].tag;
    end

    assign cnt_inc[0] = INC_W'(1);
    assign cnt_inc[1] = INC_W'(stage[WB_S].valid);
    assign cnt_inc[2] = INC_W'(stall);
    assign cnt_inc[3] = flush ? INC_W'(FLUSH_COST) : '0;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        hzp_satcnt #(
            .W     (CNT_W),
            .INC_W (INC_W)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc_i   (cnt_inc[g]),
            .count_o (cnt_val[g])
        );
    end

    assign cnt_cycles        = cnt_val[0];
    assign cnt_retired       = cnt_val[1];
    assign cnt_stalls        = cnt_val[2];
    assign cnt_flush_bubbles = cnt_val[3];

endmodule

// File: rtl/hzp_checker.sv
module hzp_checker
    import hzp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  cfg_forward,
    input logic                  stall,
    input logic                  flush,
    input logic                  ex_valid,
    input logic                  ex_branch,
    input logic                  ex_load,
    input logic [NSTG-1:0]       occ_valid,
    input logic [NSTG*TAG_W-1:0] occ_tags,
    input logic [CNT_W-1:0]      cnt_cycles,
    input logic [CNT_W-1:0]      cnt_retired,
    input logic [CNT_W-1:0]      cnt_stalls
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    p_stall_ready_r6: assert property (@(posedge clk) disable iff (rst)
        stall |-> !in_ready);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(occ_tags[2*TAG_W-1:0]) && $stable(occ_valid[1:0]) && !occ_valid[EX_S]);

    p_flush_squash_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> !occ_valid[ID_S] && !occ_valid[EX_S]);

    p_flush_src_r8: assert property (@(posedge clk) disable iff (rst)
        flush |-> ex_valid && ex_branch);

    p_fwd_loaduse_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_forward && stall) |-> ex_load);

    p_retire_step_r9: assert property (@(posedge clk) disable iff (rst)
        (occ_valid[WB_S] && cnt_retired != CMAX) |=> cnt_retired == $past(cnt_retired) + 1'b1);

    p_retire_bubble_r9: assert property (@(posedge clk) disable iff (rst)
        !occ_valid[WB_S] |=> $stable(cnt_retired));

    p_stall_count_r6: assert property (@(posedge clk) disable iff (rst)
        (stall && cnt_stalls != CMAX) |=> cnt_stalls == $past(cnt_stalls) + 1'b1);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_cycles == CMAX |=> cnt_cycles == CMAX);

    p_accept_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> occ_valid[IF_S]);

endmodule

bind hzpipe_model hzp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .cfg_forward (cfg_forward),
    .stall       (stall),
    .flush       (flush),
    .ex_valid    (stage[hzp_pkg::EX_S].valid),
    .ex_branch   (stage[hzp_pkg::EX_S].branch),
    .ex_load     (stage[hzp_pkg::EX_S].load),
    .occ_valid   (occ_valid),
    .occ_tags    (occ_tags),
    .cnt_cycles  (cnt_cycles),
    .cnt_retired (cnt_retired),
    .cnt_stalls  (cnt_stalls)
);

// File: tb/tb_hzpipe_model.sv
module tb_hzpipe_model;
    import hzp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready, in_ready_s;
    logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic in_rs1_used = 1'b0, in_rs2_used = 1'b0, in_wr_en = 1'b0;
    logic in_is_load = 1'b0, in_is_branch = 1'b0, in_br_taken = 1'b0;
    logic cfg_forward = 1'b0, cfg_predict_nt = 1'b0, drain = 1'b0;
    logic [4:0]  occ_valid, occ_valid_s;
    logic [39:0] occ_tags, occ_tags_s;
    logic [31:0] c_cyc, c_ret, c_stl, c_fl;
    logic [3:0]  s_cyc, s_ret, s_stl, s_fl;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hzpipe_model dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_rs1_used(in_rs1_used), .in_rs2_used(in_rs2_used), .in_wr_en(in_wr_en),
        .in_is_load(in_is_load), .in_is_branch(in_is_branch), .in_br_taken(in_br_taken),
        .cfg_forward(cfg_forward), .cfg_predict_nt(cfg_predict_nt), .drain(drain),
        .occ_valid(occ_valid), .occ_tags(occ_tags),
        .cnt_cycles(c_cyc), .cnt_retired(c_ret), .cnt_stalls(c_stl), .cnt_flush_bubbles(c_fl)
    );

    hzpipe_model #(.CNT_W(4)) dut_small (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_s),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_rs1_used(in_rs1_used), .in_rs2_used(in_rs2_used), .in_wr_en(in_wr_en),
        .in_is_load(in_is_load), .in_is_branch(in_is_branch), .in_br_taken(in_br_taken),
        .cfg_forward(cfg_forward), .cfg_predict_nt(cfg_predict_nt), .drain(drain),
        .occ_valid(occ_valid_s), .occ_tags(occ_tags_s),
        .cnt_cycles(s_cyc), .cnt_retired(s_ret), .cnt_stalls(s_stl), .cnt_flush_bubbles(s_fl)
    );

    // Reference model state
    instr_t m [5];
    longint m_cyc, m_ret, m_stl, m_fl;
    logic [7:0] m_tag;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit needs(instr_t c, instr_t p);
        bit r = 0;
        if (c.valid && p.valid && p.wen && p.rd != 0) begin
            if (c.rs1_use && c.rs1 == p.rd) r = 1;
            if (c.rs2_use && c.rs2 == p.rd) r = 1;
        end
        return r;
    endfunction

    function automatic bit m_flush();
        return m[2].valid && m[2].branch && (!cfg_predict_nt || m[2].taken);
    endfunction

    function automatic bit m_stall();
        bit h;
        if (cfg_forward) h = needs(m[1], m[2]) && m[2].load;
        else             h = needs(m[1], m[2]) || needs(m[1], m[3]);
        return h && !m_flush();
    endfunction

    function automatic longint sat4(longint v);
        return (v > 15) ? 15 : v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 5; i++) m[i] = '0;
        m_cyc = 0; m_ret = 0; m_stl = 0; m_fl = 0; m_tag = 0;
    endtask

    task automatic compare_state();
        logic [4:0] ev;
        for (int i = 0; i < 5; i++) ev[i] = m[i].valid;
        check(occ_valid == ev, "R2 occupancy", occ_valid, ev);
        for (int i = 0; i < 5; i++)
            if (m[i].valid)
                check(occ_tags[i*8 +: 8] == m[i].tag, "R12 stage tag", occ_tags[i*8 +: 8], m[i].tag);
        check(c_cyc == m_cyc, "R9 cycles", c_cyc, m_cyc);
        check(c_ret == m_ret, "R9 retired", c_ret, m_ret);
        check(c_stl == m_stl, "R6 stalls", c_stl, m_stl);
        check(c_fl  == m_fl,  "R7 flush bubbles", c_fl, m_fl);
        check(s_cyc == sat4(m_cyc), "R10 sat cycles", s_cyc, sat4(m_cyc));
        check(s_ret == sat4(m_ret), "R10 sat retired", s_ret, sat4(m_ret));
        check(s_fl  == sat4(m_fl),  "R10 sat flush", s_fl, sat4(m_fl));
    endtask

    // One clock with the inputs currently driven; returns whether accepted.
    task automatic cycle(output bit acc);
        bit st, fl, er;
        instr_t f, n [5];
        #1;
        st = m_stall();
        fl = m_flush();
        er = !st && !drain;
        check(in_ready == er, drain ? "R11 ready" : "R6 ready", in_ready, er);
        acc = in_valid && er;
        f = '0;
        if (acc) begin
            f.valid = 1; f.tag = m_tag; f.rd = in_rd; f.rs1 = in_rs1; f.rs2 = in_rs2;
            f.rs1_use = in_rs1_used; f.rs2_use = in_rs2_used; f.wen = in_wr_en;
            f.load = in_is_load; f.branch = in_is_branch; f.taken = in_br_taken;
            m_tag++;
        end
        m_cyc++;
        if (m[4].valid) m_ret++;
        if (st) m_stl++;
        if (fl) m_fl += 2;
        n[4] = m[3];
        n[3] = m[2];
        n[2] = (fl || st) ? '0 : m[1];
        n[1] = fl ? '0 : (st ? m[1] : m[0]);
        n[0] = fl ? f : (st ? m[0] : f);
        for (int i = 0; i < 5; i++) m[i] = n[i];
        @(posedge clk);
        #1;
        compare_state();
    endtask

    task automatic do_reset();
        in_valid = 0; drain = 0; rst = 1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 0;
        model_clear();
        check(occ_valid == 0, "R1 stages empty", occ_valid, 0);
        check(c_cyc == 0 && c_ret == 0 && c_stl == 0 && c_fl == 0, "R1 counters", c_cyc + c_ret + c_stl + c_fl, 0);
        #1;
        check(in_ready == 1, "R1 ready", in_ready, 1);
    endtask

    task automatic set_desc(input int rd, input int rs1, input int rs2, input bit u1, input bit u2,
                            input bit wen, input bit ld, input bit br, input bit tk);
        in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
        in_rs1_used = u1; in_rs2_used = u2; in_wr_en = wen;
        in_is_load = ld; in_is_branch = br; in_br_taken = tk;
    endtask

    task automatic send();
        bit acc;
        in_valid = 1;
        do cycle(acc); while (!acc);
        in_valid = 0;
    endtask

    task automatic idle(input int n);
        bit acc;
        in_valid = 0;
        for (int i = 0; i < n; i++) cycle(acc);
    endtask

    task automatic pair(input bit fwd, input bit ld, input int rd, input bit u1, input bit wen,
                        input longint exp_stall, input string req);
        cfg_forward = fwd;
        do_reset();
        set_desc(rd, 0, 0, 0, 0, wen, ld, 0, 0); send();
        set_desc(7, rd, 0, u1, 0, 1, 0, 0, 0); send();
        idle(8);
        check(c_stl == exp_stall, req, c_stl, exp_stall);
        check(c_ret == 2, req, c_ret, 2);
    endtask

    task automatic branch_case(input bit pnt, input bit tk, input longint exp_fl, input longint exp_ret,
                               input string req);
        cfg_forward = 1; cfg_predict_nt = pnt;
        do_reset();
        set_desc(0, 0, 0, 0, 0, 0, 0, 1, tk); send();
        set_desc(3, 0, 0, 0, 0, 1, 0, 0, 0); send();
        set_desc(4, 0, 0, 0, 0, 1, 0, 0, 0); send();
        idle(8);
        check(c_fl == exp_fl, req, c_fl, exp_fl);
        check(c_ret == exp_ret, req, c_ret, exp_ret);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        bit acc;
        void'($urandom(32'd4242));
        model_clear();

        // R1 reset, R2 ideal flow
        cfg_forward = 0; cfg_predict_nt = 0;
        do_reset();
        for (int i = 0; i < 10; i++) begin
            set_desc(i % 8 + 1, 0, 0, 0, 0, 1, 0, 0, 0);
            send();
        end
        idle(5);
        check(c_ret == 10, "R2 retired ideal", c_ret, 10);
        check(c_cyc == 15, "R2 cycles ideal", c_cyc, 15);
        check(c_stl == 0, "R2 no stalls", c_stl, 0);

        // R4 / R5 / R3 dependency pairs
        pair(0, 0, 5, 1, 1, 2, "R4 back-to-back no forwarding");
        pair(1, 0, 5, 1, 1, 0, "R5 forwarded alu dependency");
        pair(1, 1, 5, 1, 1, 1, "R5 load-use with forwarding");
        pair(0, 1, 5, 1, 1, 2, "R4 load without forwarding");
        pair(0, 0, 0, 1, 1, 0, "R3 register zero");
        pair(0, 0, 5, 0, 1, 0, "R3 source unused");
        pair(0, 0, 5, 1, 0, 0, "R3 producer no write");

        // R7 / R8 branch policies
        branch_case(0, 0, 2, 1, "R8 always flush not-taken");
        branch_case(0, 1, 2, 1, "R7 always flush taken");
        branch_case(1, 0, 0, 3, "R8 predict not-taken correct");
        branch_case(1, 1, 2, 1, "R8 predict not-taken wrong");

        // R11 drain
        cfg_forward = 0; cfg_predict_nt = 0;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            set_desc(i + 1, 0, 0, 0, 0, 1, 0, 0, 0); send();
        end
        drain = 1; in_valid = 1;
        for (int i = 0; i < 6; i++) cycle(acc);
        check(occ_valid == 0, "R11 drained", occ_valid, 0);
        check(c_ret == 3, "R11 retired", c_ret, 3);
        drain = 0; in_valid = 0;

        // Random traces under all four setting combinations
        for (int mode = 0; mode < 4; mode++) begin
            cfg_forward = mode[0]; cfg_predict_nt = mode[1];
            do_reset();
            for (int k = 0; k < 300; k++) begin
                set_desc($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                         1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0),
                         1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)));
                in_valid = 1'($urandom_range(0, 3) != 0);
                drain = 1'($urandom_range(0, 15) == 0);
                cycle(acc);
            end
            drain = 0;
            idle(8);
            check(occ_valid == 0, "R9 random trace drains", occ_valid, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule